// File: doc/BRIEF.md
# NAND Sector ECC Syndrome Checker and Corrector

This block takes the Hamming-style parity codes for every 512-byte sector of one NAND page and judges each sector's data. Each sector has two 24-bit codes: the one kept in the spare area and the one just computed over the data as it was read back. The block compares them and gives each sector one of four verdicts: clean, one data bit to repair, damage confined to the stored code, or beyond repair. For a repairable sector it reports which byte and which bit hold the error.

A single `start` pulse loads the codes for a whole page. The block then steps through the sectors in order, one per clock, and raises a one-cycle `done` for each verdict. The verdict registers hold their values until the next sector's result replaces them. While a verdict is held, a read-modify-write port lets the caller pass a data byte through the block. If that byte sits at the faulty offset, it comes back with the faulty bit flipped. A page that was erased and never written is treated as clean: its stored code reads all ones while the code computed over its data is all zeros.

Top module: `nand_ecc_correct`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `status` is 0.
- R2: A `start` while idle captures `storedPage` and `calcPage`. Sector k's codes are bits [24k+23:24k]. Sector k's verdict appears with `done` high and `sectorOut`=k in the cycle after the (k+1)-th clock edge following the capturing edge. `busy` is high from the cycle after the capture until the last verdict edge. A `start` while `busy` is ignored, as are page input changes after the capture.
- R3: When the two codes of a sector are equal, `status` is 0 (clean) and `errByte`/`errBit` are 0.
- R4: Each code packs 12 even parities E[11:0] and 12 odd parities O[11:0] as {O[11:8], E[11:8], O[7:0], E[7:0]}. Parity bit i covers bit addresses whose address bit i is 0 (even) or 1 (odd). The sector bit address is byte*8+bit. The syndrome is the XOR of the two unpacked codes. If 12 syndrome bits are set, `status` is 1 (corrected), `errByte` is syndrome O[11:3] and `errBit` is O[2:0].
- R5: If exactly 1 syndrome bit is set, `status` is 2 (code error) and `errByte`/`errBit` are 0.
- R6: Any other non-zero syndrome weight gives `status` 3 (uncorrectable) with `errByte`/`errBit` 0.
- R7: A stored code of 24'hFFFFFF together with a computed code of 0 gives `status` 0. The reverse pairing does not get this exception.
- R8: `fixByteOut` equals `fixByteIn` with bit `errBit` inverted when the held `status` is 1 and `fixOffset` equals `errByte`. Otherwise `fixByteOut` equals `fixByteIn` unchanged.
- R9: Each page gives exactly SECTORS `done` cycles, and `done` is 0 in the first cycle after the last of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture the page codes and begin checking |
| storedPage | input | SECTORS*24 | Codes read from the spare area, sector 0 in the low bits |
| calcPage | input | SECTORS*24 | Codes computed over the read data, same layout |
| busy | output | 1 | Sectors still being judged |
| done | output | 1 | A new sector verdict is presented this cycle |
| sectorOut | output | IDX_W | Sector index of the presented verdict |
| status | output | 2 | 0 clean, 1 corrected, 2 code error, 3 uncorrectable |
| errByte | output | 9 | Byte offset of the faulty bit within the sector |
| errBit | output | 3 | Bit index of the faulty bit within the byte |
| fixOffset | input | 9 | Offset of the byte presented for repair |
| fixByteIn | input | 8 | Byte presented for repair |
| fixByteOut | output | 8 | Repaired (or unchanged) byte |

## Verification
A wrong sector index or a stuck counter shows at the ports in the very next verdict cycle. The pairing of `sectorOut` with the verdict slips, or `busy` falls early or late. A bad syndrome unpacking or a wrong weight threshold shows in the first affected verdict as a wrong `status`, or as a location that does not match the injected bit address. For that reason every one of the 4096 single-bit addresses is injected once and its location compared. The repair port is checked in the same cycle as each verdict, both at the faulty offset and next to it, so a wrong flip mask is seen without delay.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int PAR_BITS = 12;
  localparam int CODE_W   = 2 * PAR_BITS;
  localparam int BIT_W    = 3;
  localparam int BYTE_W   = PAR_BITS - BIT_W;
  localparam int FIX_WEIGHT = PAR_BITS;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_FIXED = 2'd1,
    ST_CODE  = 2'd2,
    ST_FATAL = 2'd3
  } secStatus_e;

  typedef struct packed {
    logic load;
    logic step;
    logic last;
  } ctlStrobe_t;

  function automatic logic [PAR_BITS-1:0] evenPart(input logic [CODE_W-1:0] c);
    return {c[19:16], c[7:0]};
  endfunction

  function automatic logic [PAR_BITS-1:0] oddPart(input logic [CODE_W-1:0] c);
    return {c[23:20], c[15:8]};
  endfunction
endpackage

// File: rtl/nand_ecc_classify.sv
module nand_ecc_classify
  import nand_ecc_pkg::*;
(
  input  logic [CODE_W-1:0] storedCode,
  input  logic [CODE_W-1:0] calcCode,
  output secStatus_e        verdict,
  output logic [BYTE_W-1:0] byteOff,
  output logic [BIT_W-1:0]  bitIdx
);
  logic [PAR_BITS-1:0] synEven;
  logic [PAR_BITS-1:0] synOdd;
  logic [4:0]          weight;
  logic                erased;

  always_comb begin
    synEven = evenPart(storedCode) ^ evenPart(calcCode);
    synOdd  = oddPart(storedCode) ^ oddPart(calcCode);
    weight  = 5'($countones({synOdd, synEven}));
    erased  = (storedCode == {CODE_W{1'b1}}) && (calcCode == '0);
    byteOff = '0;
    bitIdx  = '0;
    if (erased || weight == 5'd0) begin
      verdict = ST_CLEAN;
    end else if (weight == 5'(FIX_WEIGHT)) begin
      verdict = ST_FIXED;
      byteOff = synOdd[PAR_BITS-1:BIT_W];
      bitIdx  = synOdd[BIT_W-1:0];
    end else if (weight == 5'd1) begin
      verdict = ST_CODE;
    end else begin
      verdict = ST_FATAL;
    end
  end
endmodule

// File: rtl/nand_ecc_ctrl.sv
module nand_ecc_ctrl
  import nand_ecc_pkg::*;
#(
  parameter int SECTORS = 4,
  parameter int IDX_W   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output ctlStrobe_t       strobe,
  output logic [IDX_W-1:0] sectorIdx,
  output logic             busy
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SECTORS - 1);

  always_comb begin
    strobe.load = start && !busy;
    strobe.step = busy;
    strobe.last = busy && (sectorIdx == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      sectorIdx <= '0;
    end else if (strobe.load) begin
      busy      <= 1'b1;
      sectorIdx <= '0;
    end else if (busy) begin
      if (strobe.last) begin
        busy      <= 1'b0;
        sectorIdx <= '0;
      end else begin
        sectorIdx <= IDX_W'(sectorIdx + 1'b1);
      end
    end
  end

  p_busy_ends_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.last |=> !busy);
  p_first_sector_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> sectorIdx == '0);
endmodule

// File: rtl/nand_ecc_datapath.sv
module nand_ecc_datapath
  import nand_ecc_pkg::*;
#(
  parameter int SECTORS = 4,
  parameter int IDX_W   = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobe_t                strobe,
  input  logic [IDX_W-1:0]          sectorIdx,
  input  logic [SECTORS*CODE_W-1:0] storedPage,
  input  logic [SECTORS*CODE_W-1:0] calcPage,
  output logic                      done,
  output logic [IDX_W-1:0]          sectorOut,
  output logic [1:0]                status,
  output logic [BYTE_W-1:0]         errByte,
  output logic [BIT_W-1:0]          errBit,
  input  logic [BYTE_W-1:0]         fixOffset,
  input  logic [7:0]                fixByteIn,
  output logic [7:0]                fixByteOut
);
  logic [SECTORS*CODE_W-1:0] heldStored;
  logic [SECTORS*CODE_W-1:0] heldCalc;
  logic [CODE_W-1:0]         storedSlice [SECTORS];
  logic [CODE_W-1:0]         calcSlice   [SECTORS];
  secStatus_e                curVerdict;
  logic [BYTE_W-1:0]         curByte;
  logic [BIT_W-1:0]          curBit;
  logic                      flipHit;

  for (genvar g = 0; g < SECTORS; g++) begin : g_slice
    assign storedSlice[g] = heldStored[g*CODE_W +: CODE_W];
    assign calcSlice[g]   = heldCalc[g*CODE_W +: CODE_W];
  end

  nand_ecc_classify classifier (
    .storedCode (storedSlice[sectorIdx]),
    .calcCode   (calcSlice[sectorIdx]),
    .verdict    (curVerdict),
    .byteOff    (curByte),
    .bitIdx     (curBit)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldStored <= '0;
      heldCalc   <= '0;
      done       <= 1'b0;
      sectorOut  <= '0;
      status     <= ST_CLEAN;
      errByte    <= '0;
      errBit     <= '0;
    end else begin
      if (strobe.load) begin
        heldStored <= storedPage;
        heldCalc   <= calcPage;
      end
      done <= strobe.step;
      if (strobe.step) begin
        sectorOut <= sectorIdx;
        status    <= curVerdict;
        errByte   <= curByte;
        errBit    <= curBit;
      end
    end
  end

  always_comb begin
    flipHit    = (status == ST_FIXED) && (fixOffset == errByte);
    fixByteOut = fixByteIn ^ (flipHit ? 8'(8'd1 << errBit) : 8'h00);
  end

  p_last_index_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.last |-> sectorIdx == IDX_W'(SECTORS - 1));
  p_sector_order_r2: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(done)) |-> sectorOut == IDX_W'($past(sectorOut) + 1'b1));
  p_clean_no_loc_r3: assert property (@(posedge clk) disable iff (!rstN)
    (status == ST_CLEAN) |-> (errByte == '0 && errBit == '0));
  p_code_no_loc_r5: assert property (@(posedge clk) disable iff (!rstN)
    (status == ST_CODE) |-> (errByte == '0 && errBit == '0));
  p_fatal_no_loc_r6: assert property (@(posedge clk) disable iff (!rstN)
    (status == ST_FATAL) |-> (errByte == '0 && errBit == '0));
  p_fix_one_bit_r8: assert property (@(posedge clk) disable iff (!rstN)
    (status == ST_FIXED && fixOffset == errByte) |-> $countones(fixByteOut ^ fixByteIn) == 1);
  p_fix_passthru_r8: assert property (@(posedge clk) disable iff (!rstN)
    (status != ST_FIXED) |-> fixByteOut == fixByteIn);
endmodule

// File: rtl/nand_ecc_correct.sv
module nand_ecc_correct
  import nand_ecc_pkg::*;
#(
  parameter int SECTORS = 4,
  parameter int IDX_W   = (SECTORS > 1) ? $clog2(SECTORS) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [SECTORS*CODE_W-1:0] storedPage,
  input  logic [SECTORS*CODE_W-1:0] calcPage,
  output logic                      busy,
  output logic                      done,
  output logic [IDX_W-1:0]          sectorOut,
  output logic [1:0]                status,
  output logic [BYTE_W-1:0]         errByte,
  output logic [BIT_W-1:0]          errBit,
  input  logic [BYTE_W-1:0]         fixOffset,
  input  logic [7:0]                fixByteIn,
  output logic [7:0]                fixByteOut
);
  ctlStrobe_t       strobe;
  logic [IDX_W-1:0] sectorIdx;

  nand_ecc_ctrl #(.SECTORS(SECTORS), .IDX_W(IDX_W)) ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .strobe    (strobe),
    .sectorIdx (sectorIdx),
    .busy      (busy)
  );

  nand_ecc_datapath #(.SECTORS(SECTORS), .IDX_W(IDX_W)) datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .sectorIdx  (sectorIdx),
    .storedPage (storedPage),
    .calcPage   (calcPage),
    .done       (done),
    .sectorOut  (sectorOut),
    .status     (status),
    .errByte    (errByte),
    .errBit     (errBit),
    .fixOffset  (fixOffset),
    .fixByteIn  (fixByteIn),
    .fixByteOut (fixByteOut)
  );
endmodule

// File: tb/nand_ecc_correct_test.sv
`timescale 1ns/1ps
module nand_ecc_correct_test;
  localparam int SECTORS = 4;
  localparam int IDX_W = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [SECTORS*24-1:0] storedPage = '0;
  logic [SECTORS*24-1:0] calcPage = '0;
  logic busy, done;
  logic [IDX_W-1:0] sectorOut;
  logic [1:0] status;
  logic [8:0] errByte;
  logic [2:0] errBit;
  logic [8:0] fixOffset = '0;
  logic [7:0] fixByteIn = '0;
  logic [7:0] fixByteOut;

  int checks = 0;
  int errors = 0;

  logic [23:0] stv [SECTORS];
  logic [23:0] clv [SECTORS];
  logic [1:0]  eSt [SECTORS];
  logic [8:0]  eByte [SECTORS];
  logic [2:0]  eBit [SECTORS];

  always #4 clk = ~clk;

  nand_ecc_correct #(.SECTORS(SECTORS)) uut (
    .clk(clk), .rstN(rstN), .start(start),
    .storedPage(storedPage), .calcPage(calcPage),
    .busy(busy), .done(done), .sectorOut(sectorOut), .status(status),
    .errByte(errByte), .errBit(errBit),
    .fixOffset(fixOffset), .fixByteIn(fixByteIn), .fixByteOut(fixByteOut)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] pack(input logic [11:0] ev, input logic [11:0] od);
    return {od[11:8], ev[11:8], od[7:0], ev[7:0]};
  endfunction

  // Expected verdict from the syndrome weight rules (R3, R5, R6) for a mask
  function automatic logic [1:0] weightVerdict(input logic [23:0] m);
    int w = $countones(m);
    if (w == 0) return 2'd0;
    if (w == 12) return 2'd1;
    if (w == 1) return 2'd2;
    return 2'd3;
  endfunction

  task automatic runPage(input bit disturb);
    @(negedge clk);
    for (int k = 0; k < SECTORS; k++) begin
      storedPage[k*24 +: 24] = stv[k];
      calcPage[k*24 +: 24]   = clv[k];
    end
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R2", "busy after start", int'(busy), 1);
    check("R2", "no done before first step", int'(done), 0);
    if (disturb) begin
      storedPage = ~storedPage;
      calcPage   = {SECTORS{24'h5A5A5A}};
    end else begin
      start = 1'b0;
    end
    for (int k = 0; k < SECTORS; k++) begin
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      check("R2", "done for sector", int'(done), 1);
      check("R2", "sector index", int'(sectorOut), k);
      check("R2", "busy during page", int'(busy), (k == SECTORS - 1) ? 0 : 1);
      check(eSt[k] == 2'd1 ? "R4" : eSt[k] == 2'd2 ? "R5" : eSt[k] == 2'd3 ? "R6" : "R3",
            "status", int'(status), int'(eSt[k]));
      check("R4", "error byte", int'(errByte), int'(eByte[k]));
      check("R4", "error bit", int'(errBit), int'(eBit[k]));
      fixByteIn = 8'($urandom);
      if (eSt[k] == 2'd1) begin
        fixOffset = eByte[k];
        #1;
        check("R8", "flip at offset", int'(fixByteOut), int'(fixByteIn ^ (8'd1 << eBit[k])));
        fixOffset = eByte[k] ^ 9'd1;
        #1;
        check("R8", "neighbour untouched", int'(fixByteOut), int'(fixByteIn));
      end else begin
        fixOffset = 9'($urandom);
        #1;
        check("R8", "no flip without correction", int'(fixByteOut), int'(fixByteIn));
      end
    end
    @(posedge clk);
    @(negedge clk);
    check("R9", "done low after page", int'(done), 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "busy in reset", int'(busy), 0);
    check("R1", "done in reset", int'(done), 0);
    check("R1", "status in reset", int'(status), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "idle after reset", int'(busy), 0);

    // R3: clean sectors
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < SECTORS; k++) begin
        clv[k] = 24'($urandom); stv[k] = clv[k];
        eSt[k] = 2'd0; eByte[k] = '0; eBit[k] = '0;
      end
      runPage(1'b0);
    end

    // R4: every single-bit data error address
    for (int a = 0; a < 4096; a += SECTORS) begin
      for (int k = 0; k < SECTORS; k++) begin
        logic [11:0] addr;
        addr = 12'(a + k);
        clv[k] = 24'($urandom);
        stv[k] = clv[k] ^ pack(~addr, addr);
        eSt[k] = 2'd1; eByte[k] = addr[11:3]; eBit[k] = addr[2:0];
      end
      runPage(1'b0);
    end

    // R5: every single flipped code bit
    for (int b = 0; b < 24; b += SECTORS) begin
      for (int k = 0; k < SECTORS; k++) begin
        clv[k] = 24'($urandom);
        stv[k] = clv[k] ^ (24'd1 << (b + k));
        eSt[k] = 2'd2; eByte[k] = '0; eBit[k] = '0;
      end
      runPage(1'b0);
    end

    // R6: uncorrectable weights
    for (int p = 0; p < 16; p++) begin
      for (int k = 0; k < SECTORS; k++) begin
        logic [23:0] m;
        m = 24'($urandom);
        if (p == 0) m = 24'h000003;
        if (p == 1) m = 24'h000FFF ^ 24'h800000;
        if (weightVerdict(m) != 2'd3) m = 24'h0000F0;
        clv[k] = 24'($urandom);
        stv[k] = clv[k] ^ m;
        eSt[k] = 2'd3; eByte[k] = '0; eBit[k] = '0;
      end
      runPage(1'b0);
    end

    // R7: erased page exception and its limits
    stv[0] = 24'hFFFFFF; clv[0] = 24'h000000; eSt[0] = 2'd0;
    stv[1] = 24'hFFFFFF; clv[1] = 24'h000001; eSt[1] = 2'd3;
    stv[2] = 24'h000000; clv[2] = 24'hFFFFFF; eSt[2] = 2'd3;
    stv[3] = 24'hFFFFFF; clv[3] = 24'hFFFFFF; eSt[3] = 2'd0;
    for (int k = 0; k < SECTORS; k++) begin eByte[k] = '0; eBit[k] = '0; end
    runPage(1'b0);

    // R2: start and input changes while busy are ignored
    for (int k = 0; k < SECTORS; k++) begin
      logic [11:0] addr;
      addr = 12'(1000 * k + 7);
      clv[k] = 24'($urandom);
      stv[k] = clv[k] ^ pack(~addr, addr);
      eSt[k] = 2'd1; eByte[k] = addr[11:3]; eBit[k] = addr[2:0];
    end
    runPage(1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule